// File: doc/BRIEF.md
# Hit-and-Miss Binary Template Correlator

This block searches a raster-ordered grayscale pixel stream for a target described by a square binary template of N by N cells. Every cell carries a two-bit code that marks it as a bright cell, a surround cell or a cell that takes no part. Pixels are accepted on a valid/ready stream. Each pixel arrives with a threshold. That threshold belongs to the window whose bottom-right corner is that pixel. The threshold is computed upstream and differs from one position to the next.

For each window that lies wholly inside the image, one processing element per cell compares its pixel against the window's threshold. A bright cell scores when the pixel is strictly above the threshold. A surround cell scores when the pixel is strictly below it. Both tallies go down a fixed pipeline to a result stream, which carries the two counts and a detect flag. Detection needs both tallies to reach their own programmable limits.

Between the rows of the array, the pixel history sits in row memories of width minus N entries each. Template cells and limits are written through simple load ports while the block is idle. A load attempted while the block is busy is dropped and latches an error flag.

Top module: `hmc_correlator`

## Requirements
- R1: A cell with code 2'b01 (bright) adds one to the bright count only when its pixel is strictly greater than the window threshold. A pixel equal to the threshold does not count.
- R2: A cell with code 2'b10 (surround) adds one to the surround count only when its pixel is strictly less than the window threshold. A pixel equal to the threshold does not count.
- R3: Cells with code 2'b00 or 2'b11 add to neither count. Template cell index is row*N+column, with row 0 at the top of the window and column 0 at its left.
- R4: out_detect is 1 exactly when out_bright >= the bright limit and out_surround >= the surround limit.
- R5: The threshold sampled with a pixel applies only to the window whose bottom-right pixel that is.
- R6: One result is produced for every window whose bottom-right pixel has row >= N-1 and column >= N-1, in raster order. Windows that would wrap across a row edge or a frame edge produce no result. Position counters wrap at IMG_W columns and IMG_H rows.
- R7: out_valid for a window rises exactly N+2 clock edges after the edge that accepts its bottom-right pixel.
- R8: A template or limit load while any pixel is offered or in flight is ignored and sets cfg_err. cfg_err stays set until reset.
- R9: Reset clears out_valid, cfg_err, the position counters and all pipeline valid bits. It sets every template cell to 2'b00 and both limits to 0, and in_ready is 1 after reset.
- R10: Counts are $clog2(N*N+1) bits wide. A window that hits on all N*N cells reports N*N.
- R11: Cycles with in_valid low do not disturb the window contents. Results with gaps in the input stream equal the results without gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Pixel beat offered |
| in_ready | output | 1 | Block accepts pixels |
| in_pix | input | PIX_W | Pixel intensity |
| in_thr | input | PIX_W | Threshold for the window ending at this pixel |
| tpl_we | input | 1 | Template cell write strobe |
| tpl_idx | input | $clog2(N*N) | Cell index row*N+column |
| tpl_code | input | 2 | Cell code: 01 bright, 10 surround, 00/11 unused |
| lim_we | input | 1 | Limit write strobe |
| lim_bright | input | $clog2(N*N+1) | Bright count limit |
| lim_surround | input | $clog2(N*N+1) | Surround count limit |
| out_valid | output | 1 | Result valid |
| out_bright | output | $clog2(N*N+1) | Bright hit count |
| out_surround | output | $clog2(N*N+1) | Surround hit count |
| out_detect | output | 1 | Both limits reached |
| cfg_err | output | 1 | Sticky rejected-load flag |

## Verification
The bench feeds pixels equal to their thresholds under all-bright and all-surround templates. A design that compared with >= or <= would report nonzero counts there. A centre-bright ring target is set with the surround limit exactly at eight. An off-by-one limit compare would then flag neighbouring windows or miss the target itself. Mixed templates that include code 11, with thresholds that vary per pixel, catch a wrong threshold-to-window association or a row-buffer depth that is off by one. The bench also checks that windows across a row edge produce no result and that result latency is exactly N+2. A load issued alongside streaming must leave the template untouched and latch cfg_err.

// File: rtl/hmc_pkg.sv
package hmc_pkg;
  typedef enum logic [1:0] {
    CELL_OFF    = 2'b00,
    CELL_BRIGHT = 2'b01,
    CELL_SURR   = 2'b10,
    CELL_SPARE  = 2'b11
  } cell_code_e;
endpackage

// File: rtl/hmc_rowbuf.sv
module hmc_rowbuf #(
  parameter int DEPTH = 5,
  parameter int PW    = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [PW-1:0] din,
  output logic [PW-1:0] dout
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [PW-1:0] mem [DEPTH];
  logic [AW-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (en) begin
      dout     <= mem[ptr_q];
      mem[ptr_q] <= din;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ptr_q <= '0;
    else if (en) ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + AW'(1);
  end

  // R11
  ptr_range_chk: assert property (@(posedge clk) disable iff (rst) ptr_q <= LAST);
endmodule

// File: rtl/hmc_window.sv
module hmc_window #(
  parameter int N     = 3,
  parameter int IMG_W = 8,
  parameter int PW    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [PW-1:0]     pix,
  output logic [N*N*PW-1:0] win
);
  localparam int DEPTH = IMG_W - N;

  logic [N-1:0][N-2:0][PW-1:0] sh_q;
  logic [PW-1:0] newest_q;
  logic [PW-1:0] tail [N-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q     <= '0;
      newest_q <= '0;
    end else if (en) begin
      newest_q <= pix;
      for (int k = 0; k < N; k++) begin
        for (int j = 0; j < N-2; j++) sh_q[k][j] <= sh_q[k][j+1];
      end
      for (int k = 0; k < N-1; k++) sh_q[k][N-2] <= tail[k];
      sh_q[N-1][N-2] <= newest_q;
    end
  end

  for (genvar k = 0; k < N-1; k++) begin : g_buf
    hmc_rowbuf #(.DEPTH(DEPTH), .PW(PW)) u_buf (
      .clk (clk),
      .rst (rst),
      .en  (en),
      .din (sh_q[k+1][0]),
      .dout(tail[k])
    );
  end

  for (genvar k = 0; k < N; k++) begin : g_row
    for (genvar j = 0; j < N; j++) begin : g_col
      if (j < N-1) begin : g_sh
        assign win[(k*N+j)*PW +: PW] = sh_q[k][j];
      end else if (k == N-1) begin : g_new
        assign win[(k*N+j)*PW +: PW] = newest_q;
      end else begin : g_tail
        assign win[(k*N+j)*PW +: PW] = tail[k];
      end
    end
  end
endmodule

// File: rtl/hmc_score.sv
module hmc_score
  import hmc_pkg::*;
#(
  parameter int N  = 3,
  parameter int PW = 8,
  parameter int CW = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              win_vld,
  input  logic [N*N*PW-1:0] win,
  input  logic [PW-1:0]     thr,
  input  logic [N*N*2-1:0]  tpl,
  input  logic [CW-1:0]     lim_b,
  input  logic [CW-1:0]     lim_s,
  output logic              busy,
  output logic              out_vld,
  output logic [CW-1:0]     out_b,
  output logic [CW-1:0]     out_s,
  output logic              out_det
);
  localparam logic [CW-1:0] CELLS = CW'(N*N);

  logic [CW-1:0] rb_c [N];
  logic [CW-1:0] rs_c [N];
  logic [CW-1:0] s1_rb [N];
  logic [CW-1:0] s1_rs [N];
  logic          s1_v;
  logic [CW-1:0] rowb_d [N];
  logic [CW-1:0] rows_d [N];
  logic [CW-1:0] accb_q [N];
  logic [CW-1:0] accs_q [N];
  logic [N-1:0]  v_q;

  // one processing element per cell, summed by row
  always_comb begin
    for (int k = 0; k < N; k++) begin
      rb_c[k] = '0;
      rs_c[k] = '0;
      for (int j = 0; j < N; j++) begin
        if (cell_code_e'(tpl[(k*N+j)*2 +: 2]) == CELL_BRIGHT &&
            win[(k*N+j)*PW +: PW] > thr)
          rb_c[k] = rb_c[k] + CW'(1);
        if (cell_code_e'(tpl[(k*N+j)*2 +: 2]) == CELL_SURR &&
            win[(k*N+j)*PW +: PW] < thr)
          rs_c[k] = rs_c[k] + CW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v <= 1'b0;
      for (int k = 0; k < N; k++) begin
        s1_rb[k] <= '0;
        s1_rs[k] <= '0;
      end
    end else begin
      s1_v <= win_vld;
      for (int k = 0; k < N; k++) begin
        s1_rb[k] <= rb_c[k];
        s1_rs[k] <= rs_c[k];
      end
    end
  end

  // row k joins the running sum k cycles later
  for (genvar a = 0; a < N; a++) begin : g_dly
    if (a == 0) begin : g_now
      assign rowb_d[a] = s1_rb[0];
      assign rows_d[a] = s1_rs[0];
    end else begin : g_line
      logic [CW-1:0] db [a];
      logic [CW-1:0] ds [a];
      always_ff @(posedge clk) begin
        db[0] <= s1_rb[a];
        ds[0] <= s1_rs[a];
        for (int i = 1; i < a; i++) begin
          db[i] <= db[i-1];
          ds[i] <= ds[i-1];
        end
      end
      assign rowb_d[a] = db[a-1];
      assign rows_d[a] = ds[a-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q <= '0;
      for (int a = 0; a < N; a++) begin
        accb_q[a] <= '0;
        accs_q[a] <= '0;
      end
    end else begin
      v_q <= {v_q[N-2:0], s1_v};
      accb_q[0] <= rowb_d[0];
      accs_q[0] <= rows_d[0];
      for (int a = 1; a < N; a++) begin
        accb_q[a] <= accb_q[a-1] + rowb_d[a];
        accs_q[a] <= accs_q[a-1] + rows_d[a];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= 1'b0;
      out_b   <= '0;
      out_s   <= '0;
      out_det <= 1'b0;
    end else begin
      out_vld <= v_q[N-1];
      out_b   <= accb_q[N-1];
      out_s   <= accs_q[N-1];
      out_det <= v_q[N-1] && (accb_q[N-1] >= lim_b) && (accs_q[N-1] >= lim_s);
    end
  end

  assign busy = s1_v | (|v_q) | out_vld;

  // R10
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> (out_b <= CELLS && out_s <= CELLS));
  // R4
  det_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    out_det |-> out_vld);
endmodule

// File: rtl/hmc_correlator.sv
module hmc_correlator #(
  parameter int N     = 3,
  parameter int IMG_W = 8,
  parameter int IMG_H = 6,
  parameter int PIX_W = 8,
  localparam int CW   = $clog2(N*N+1),
  localparam int IW   = $clog2(N*N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PIX_W-1:0] in_pix,
  input  logic [PIX_W-1:0] in_thr,
  input  logic             tpl_we,
  input  logic [IW-1:0]    tpl_idx,
  input  logic [1:0]       tpl_code,
  input  logic             lim_we,
  input  logic [CW-1:0]    lim_bright,
  input  logic [CW-1:0]    lim_surround,
  output logic             out_valid,
  output logic [CW-1:0]    out_bright,
  output logic [CW-1:0]    out_surround,
  output logic             out_detect,
  output logic             cfg_err
);
  localparam int XW = $clog2(IMG_W);
  localparam int YW = $clog2(IMG_H);
  localparam logic [XW-1:0] XLAST = XW'(IMG_W - 1);
  localparam logic [YW-1:0] YLAST = YW'(IMG_H - 1);
  localparam logic [XW-1:0] XMIN  = XW'(N - 1);
  localparam logic [YW-1:0] YMIN  = YW'(N - 1);

  logic                 rdy_q;
  logic                 fire;
  logic [XW-1:0]        col_q;
  logic [YW-1:0]        row_q;
  logic                 win_vld_q;
  logic [PIX_W-1:0]     thr_q;
  logic [N*N-1:0][1:0]  tpl_q;
  logic [CW-1:0]        limb_q;
  logic [CW-1:0]        lims_q;
  logic [N*N*PIX_W-1:0] win;
  logic                 score_busy;
  logic                 busy;

  assign in_ready = rdy_q;
  assign fire     = in_valid & rdy_q;
  assign busy     = in_valid | win_vld_q | score_busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdy_q     <= 1'b0;
      col_q     <= '0;
      row_q     <= '0;
      win_vld_q <= 1'b0;
      thr_q     <= '0;
    end else begin
      rdy_q     <= 1'b1;
      win_vld_q <= fire && (col_q >= XMIN) && (row_q >= YMIN);
      if (fire) begin
        thr_q <= in_thr;
        if (col_q == XLAST) begin
          col_q <= '0;
          row_q <= (row_q == YLAST) ? '0 : row_q + YW'(1);
        end else begin
          col_q <= col_q + XW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tpl_q   <= '0;
      limb_q  <= '0;
      lims_q  <= '0;
      cfg_err <= 1'b0;
    end else begin
      if ((tpl_we || lim_we) && busy) cfg_err <= 1'b1;
      if (tpl_we && !busy) begin
        for (int i = 0; i < N*N; i++)
          if (tpl_idx == IW'(i)) tpl_q[i] <= tpl_code;
      end
      if (lim_we && !busy) begin
        limb_q <= lim_bright;
        lims_q <= lim_surround;
      end
    end
  end

  hmc_window #(.N(N), .IMG_W(IMG_W), .PW(PIX_W)) u_win (
    .clk(clk), .rst(rst), .en(fire), .pix(in_pix), .win(win)
  );

  hmc_score #(.N(N), .PW(PIX_W), .CW(CW)) u_score (
    .clk    (clk),
    .rst    (rst),
    .win_vld(win_vld_q),
    .win    (win),
    .thr    (thr_q),
    .tpl    (tpl_q),
    .lim_b  (limb_q),
    .lim_s  (lims_q),
    .busy   (score_busy),
    .out_vld(out_valid),
    .out_b  (out_bright),
    .out_s  (out_surround),
    .out_det(out_detect)
  );

  // R8
  cfg_rejected_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && (tpl_we || lim_we)) |=> cfg_err);
  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_err |=> cfg_err);
  // R8
  tpl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(tpl_q) && $stable(limb_q) && $stable(lims_q)));
  // R6
  col_range_chk: assert property (@(posedge clk) disable iff (rst)
    col_q <= XLAST && row_q <= YLAST);
endmodule

// File: tb/hmc_correlator_test.sv
module hmc_correlator_test;
  localparam int N = 3, W = 8, H = 6, PW = 8;
  localparam int CW = $clog2(N*N+1), IW = $clog2(N*N);
  localparam int NWIN = (H-N+1)*(W-N+1);

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0, in_ready;
  logic [PW-1:0] in_pix = '0, in_thr = '0;
  logic tpl_we = 1'b0, lim_we = 1'b0;
  logic [IW-1:0] tpl_idx = '0;
  logic [1:0] tpl_code = '0;
  logic [CW-1:0] lim_bright = '0, lim_surround = '0;
  logic out_valid, out_detect, cfg_err;
  logic [CW-1:0] out_bright, out_surround;

  int checks = 0, failures = 0, pc = 0;
  int res_n = 0;
  int res_b [64], res_s [64], res_d [64], res_pc [64];
  int img [H][W], th [H][W];
  int exp_tpl [N*N];
  int exp_lb = 0, exp_ls = 0;
  int last_pc = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  hmc_correlator #(.N(N), .IMG_W(W), .IMG_H(H), .PIX_W(PW)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_pix(in_pix), .in_thr(in_thr), .tpl_we(tpl_we), .tpl_idx(tpl_idx),
    .tpl_code(tpl_code), .lim_we(lim_we), .lim_bright(lim_bright),
    .lim_surround(lim_surround), .out_valid(out_valid), .out_bright(out_bright),
    .out_surround(out_surround), .out_detect(out_detect), .cfg_err(cfg_err)
  );

  always @(posedge clk) pc <= pc + 1;

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (res_n < 64) begin
        res_b[res_n]  = int'(out_bright);
        res_s[res_n]  = int'(out_surround);
        res_d[res_n]  = int'(out_detect);
        res_pc[res_n] = pc;
      end
      res_n = res_n + 1;
    end
  end

  task automatic chk(string tag, int act, int expv, string what);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  function automatic int code_of(int mode, int idx);
    case (mode)
      1: return (idx*3 + 1) % 4;
      2: return 1;
      3: return (idx == 4) ? 1 : 2;
      4: return 2;
      default: return 0;
    endcase
  endfunction

  task automatic load_cfg(int mode, int lb, int ls);
    for (int i = 0; i < N*N; i++) begin
      tpl_we = 1'b1; tpl_idx = IW'(i); tpl_code = 2'(code_of(mode, i));
      exp_tpl[i] = code_of(mode, i);
      @(posedge clk); #1;
    end
    tpl_we = 1'b0;
    lim_we = 1'b1; lim_bright = CW'(lb); lim_surround = CW'(ls);
    exp_lb = lb; exp_ls = ls;
    @(posedge clk); #1;
    lim_we = 1'b0;
  endtask

  function automatic void fill(int pat);
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++) begin
        case (pat)
          0: begin img[r][c] = (r*37 + c*91 + 7) % 256; th[r][c] = (r*19 + c*53 + 100) % 256; end
          1: begin img[r][c] = (r*29 + c*11) % 256; th[r][c] = img[r][c]; end
          2: begin img[r][c] = 255; th[r][c] = 0; end
          default: begin img[r][c] = (r == 3 && c == 4) ? 200 : 30; th[r][c] = 100; end
        endcase
      end
  endfunction

  // gap: idle cycles after every third pixel; busy_ld: load with first pixel
  task automatic run_frame(string tag, int pat, int gap, bit busy_ld);
    int eb, es, ed, r, c;
    fill(pat);
    res_n = 0;
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++) begin
        in_valid = 1'b1; in_pix = PW'(img[y][x]); in_thr = PW'(th[y][x]);
        if (busy_ld && y == 0 && x == 0) begin
          tpl_we = 1'b1; tpl_idx = IW'(4); tpl_code = 2'b10;
          lim_we = 1'b1; lim_bright = '0; lim_surround = '0;
        end
        @(posedge clk); #1;
        tpl_we = 1'b0; lim_we = 1'b0;
        last_pc = pc;
        if (gap > 0 && (x % 3) == 1) begin
          in_valid = 1'b0;
          repeat (gap) begin @(posedge clk); #1; end
        end
      end
    in_valid = 1'b0;
    repeat (N + 6) begin @(posedge clk); #1; end
    chk(tag, res_n, NWIN, "R6 result count");
    for (int k = 0; k < NWIN && k < res_n; k++) begin
      r = N - 1 + k / (W-N+1);
      c = N - 1 + k % (W-N+1);
      eb = 0; es = 0;
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++) begin
          if (exp_tpl[i*N+j] == 1 && img[r-N+1+i][c-N+1+j] > th[r][c]) eb++;
          if (exp_tpl[i*N+j] == 2 && img[r-N+1+i][c-N+1+j] < th[r][c]) es++;
        end
      ed = (eb >= exp_lb && es >= exp_ls) ? 1 : 0;
      chk(tag, res_b[k], eb, $sformatf("R1 R3 R5 bright win %0d", k));
      chk(tag, res_s[k], es, $sformatf("R2 R3 R5 surround win %0d", k));
      chk(tag, res_d[k], ed, $sformatf("R4 detect win %0d", k));
    end
    if (res_n >= NWIN) chk(tag, res_pc[NWIN-1] - last_pc, N + 2, "R7 latency");
  endtask

  task automatic t_reset;
    chk("R9", int'(out_valid), 0, "out_valid after reset");
    chk("R9", int'(cfg_err), 0, "cfg_err after reset");
    chk("R9", int'(in_ready), 1, "in_ready after reset");
    for (int i = 0; i < N*N; i++) exp_tpl[i] = 0;
    exp_lb = 0; exp_ls = 0;
    run_frame("R9 reset template", 0, 0, 1'b0);
  endtask

  task automatic t_mixed;
    load_cfg(1, 1, 1);
    run_frame("R3 mixed codes", 0, 0, 1'b0);
  endtask

  task automatic t_strict_and_full;
    load_cfg(2, 9, 0);
    run_frame("R10 all bright full hit", 2, 0, 1'b0);
    run_frame("R1 equal pixels", 1, 0, 1'b0);
    load_cfg(4, 0, 1);
    run_frame("R2 equal pixels", 1, 0, 1'b0);
  endtask

  task automatic t_ring;
    load_cfg(3, 1, 8);
    run_frame("R4 ring limit edge", 3, 0, 1'b0);
    chk("R4", res_d[(4-N+1)*(W-N+1) + (5-N+1)], 1, "target window detected");
  endtask

  task automatic t_stall;
    load_cfg(1, 2, 1);
    run_frame("R11 gapped stream", 0, 2, 1'b0);
  endtask

  task automatic t_busy_load;
    load_cfg(3, 1, 8);
    chk("R8", int'(cfg_err), 0, "cfg_err before busy load");
    run_frame("R8 busy load ignored", 3, 0, 1'b1);
    chk("R8", int'(cfg_err), 1, "cfg_err after busy load");
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    repeat (2) begin @(posedge clk); #1; end
    t_reset();
    t_mixed();
    t_strict_and_full();
    t_ring();
    t_stall();
    t_busy_load();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule